// File: doc/BRIEF.md
# CAN Receive FIFO with Overrun Tracking

This block is the receive store of a CAN controller. A bit-level receiver hands it each accepted frame as a byte stream, one byte per `rx_valid` pulse. The first byte carries the frame information: bit 7 selects the extended format, and the low nibble is the data length. Every byte goes straight into a 64-byte circular memory as it arrives. The host sees the oldest pending frame through a 13-byte read window that starts at the read pointer. It moves on to the next frame with a release command.

When the memory fills partway through a frame, the rest of that frame's bytes are lost. The frame is still counted as a message, and it is marked as overflowed. Overrun is not reported at that moment. It is reported when a release moves the window onto the overflowed frame. The host then clears the overrun status and issues one release per remaining counted message to resynchronise. The message counter can reach 64. At that point only a reset-mode cycle recovers the block.

Top module: `can_rx_fifo`

## Requirements
- R1: A frame occupies 1 + (bit 7 of its first byte ? 4 : 2) + min(low nibble, 8) bytes. The window output byte k (bits 8k+7..8k) shows stored byte (read pointer + k) mod 64, and the window wraps around the memory.
- R2: The counter goes up by one, and the buffer-status flag rises, at the clock edge that takes the last byte of a frame. The receive interrupt flag (irq bit 0) is set one cycle after the buffer-status flag rises.
- R3: A release advances the read pointer by the current frame's stored size and lowers the counter by one. Buffer status is updated at that same edge. A release while the counter is zero changes nothing.
- R4: Bytes are stored until 64 bytes are held. Later bytes of that frame are discarded, but the frame is still counted. Overrun status does not rise at that point.
- R5: A release that lands the window on an overflowed frame raises overrun status at that edge, and buffer status stays low.
- R6: A release that leaves the counter at zero raises overrun status if the frame currently arriving has already overflowed.
- R7: The clear-overrun command clears overrun status at the next edge. The overrun interrupt flag (irq bit 3) is set one cycle after overrun status rises.
- R8: Pulsing `irq_rd` clears irq bits 0 and 3. A flag that is being set in the same cycle stays set. All other irq bits read 0.
- R9: The counter never exceeds 64. A frame whose first byte arrives while the counter is 64 is neither stored nor counted, and overrun status rises when its last byte arrives.
- R10: While `reset_mode` is high, the memory is emptied, the counter, status and irq flags are zeroed, and incoming bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode | input | 1 | Controller reset mode: flushes the store and the flags |
| rx_valid | input | 1 | One received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received frame byte |
| rel_cmd | input | 1 | Release the current frame |
| clr_ovr_cmd | input | 1 | Clear the overrun status |
| irq_rd | input | 1 | Interrupt register read strobe (clears the flags) |
| win_bytes | output | 104 | 13-byte read window at the read pointer |
| msg_count | output | 7 | Pending message count, 0 to 64 |
| buf_status | output | 1 | A valid frame is under the window |
| ovr_status | output | 1 | Data overrun status |
| irq_flags | output | 8 | Interrupt register: bit 0 receive, bit 3 overrun |

## Verification
The counter, buffer status, overrun status and read window all change at the clock edge that takes the last frame byte or the command. The bench drives on the falling edge and samples on the next falling edge. The interrupt flags lag by one more edge, so the bench checks them once before that extra cycle, expecting the old value, and once after it. The cases covered are a sweep over both formats and all sixteen length codes, a buffer filled to overflow, the counter driven to its limit, and a final release made while a partly received frame has already overflowed.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int unsigned FRAME_MAX = 13;
  localparam int unsigned LEN_W     = 4;

  typedef struct packed {
    logic             bad;
    logic [LEN_W-1:0] len;
  } slot_t;

  // Stored size of a frame from its information byte; length codes above 8 count as 8
  function automatic logic [LEN_W-1:0] frame_bytes(input logic [7:0] info);
    logic [LEN_W-1:0] d;
    d = (info[3:0] > 4'd8) ? 4'd8 : info[3:0];
    return 4'd1 + (info[7] ? 4'd4 : 4'd2) + d;
  endfunction
endpackage

// File: rtl/can_rx_store.sv
module can_rx_store #(
  parameter  int DEPTH = 64,
  parameter  int WIN   = 13,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [7:0]      wdata,
  input  logic [AW-1:0]   rbase,
  output logic [WIN*8-1:0] win
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_win
      logic [AW-1:0] idx;
      assign idx = rbase + AW'(i);
      assign win[i*8 +: 8] = mem[idx];
    end
  endgenerate
endmodule

// File: rtl/can_rx_assembler.sv
module can_rx_assembler import can_rx_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       space_ok,
  input  logic       at_limit,
  output logic       store_en,
  output logic       done,
  output logic       done_drop,
  output slot_t      done_slot,
  output logic       ovf_pend
);
  logic [LEN_W-1:0] bidx, fsize, slen;
  logic             ovf_q, drop_q;
  logic             first, drop_c, ovf_c;
  logic [LEN_W-1:0] size_c, slen_c;

  always_comb begin
    first     = (bidx == '0);
    size_c    = first ? frame_bytes(byte_in) : fsize;
    drop_c    = first ? at_limit : drop_q;
    ovf_c     = !drop_c && ((!first && ovf_q) || !space_ok);
    slen_c    = first ? '0 : slen;
    store_en  = byte_vld && !drop_c && !ovf_c;
    done      = byte_vld && ((bidx + 4'd1) == size_c);
    done_drop = drop_c;
    done_slot.bad = ovf_c;
    done_slot.len = slen_c + LEN_W'(store_en);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      bidx   <= '0;
      fsize  <= '0;
      slen   <= '0;
      ovf_q  <= 1'b0;
      drop_q <= 1'b0;
    end else if (byte_vld) begin
      if (done) begin
        bidx   <= '0;
        slen   <= '0;
        ovf_q  <= 1'b0;
        drop_q <= 1'b0;
      end else begin
        bidx   <= bidx + 4'd1;
        fsize  <= size_c;
        slen   <= done_slot.len;
        ovf_q  <= ovf_c;
        drop_q <= drop_c;
      end
    end
  end

  assign ovf_pend = ovf_q;
endmodule

// File: rtl/can_rx_index.sv
// Per-message side queue: overflow mark and stored length. SLOTS must be a power of two.
module can_rx_index import can_rx_pkg::*; #(
  parameter  int SLOTS = 64,
  localparam int QW    = $clog2(SLOTS)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  push,
  input  slot_t push_slot,
  input  logic  pop,
  output slot_t head_slot,
  output slot_t next_slot
);
  slot_t          q [SLOTS];
  logic [QW-1:0]  head, tail, head_p1;

  always_ff @(posedge clk) begin
    if (push) q[tail] <= push_slot;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (push) tail <= tail + QW'(1);
      if (pop)  head <= head + QW'(1);
    end
  end

  assign head_p1   = head + QW'(1);
  assign head_slot = q[head];
  assign next_slot = q[head_p1];
endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo import can_rx_pkg::*; #(
  parameter  int DEPTH = 64,
  parameter  int SLOTS = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = $clog2(DEPTH + 1),
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int WIN   = FRAME_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reset_mode,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rel_cmd,
  input  logic             clr_ovr_cmd,
  input  logic             irq_rd,
  output logic [WIN*8-1:0] win_bytes,
  output logic [CW-1:0]    msg_count,
  output logic             buf_status,
  output logic             ovr_status,
  output logic [7:0]       irq_flags
);
  logic [AW-1:0] wptr, rptr;
  logic [FW-1:0] fill;
  logic [CW-1:0] cnt, cnt_pop, cnt_n;
  logic          rbs_q, rbs_d, dos_q, dos_d, ri_q, doi_q;
  logic          store_en, done, done_drop, ovf_pend;
  logic          space_ok, at_limit, pop, push, rbs_n, dos_set;
  slot_t         done_slot, head_slot, next_slot, land;
  logic [LEN_W-1:0] rel_len;

  assign space_ok = (fill < FW'(DEPTH));
  assign at_limit = (cnt == CW'(SLOTS));

  can_rx_assembler u_asm (
    .clk(clk), .rst(rst), .flush(reset_mode),
    .byte_vld(rx_valid && !reset_mode), .byte_in(rx_byte),
    .space_ok(space_ok), .at_limit(at_limit),
    .store_en(store_en), .done(done), .done_drop(done_drop),
    .done_slot(done_slot), .ovf_pend(ovf_pend)
  );

  can_rx_store #(.DEPTH(DEPTH), .WIN(WIN)) u_store (
    .clk(clk), .we(store_en), .waddr(wptr), .wdata(rx_byte),
    .rbase(rptr), .win(win_bytes)
  );

  assign pop  = rel_cmd && (cnt != '0) && !reset_mode;
  assign push = done && !done_drop;

  can_rx_index #(.SLOTS(SLOTS)) u_idx (
    .clk(clk), .rst(rst), .flush(reset_mode),
    .push(push), .push_slot(done_slot), .pop(pop),
    .head_slot(head_slot), .next_slot(next_slot)
  );

  always_comb begin
    cnt_pop = cnt - CW'(pop);
    cnt_n   = cnt_pop + CW'(push);
    if (pop) land = (cnt_pop != '0) ? next_slot : done_slot;
    else     land = (cnt != '0)     ? head_slot : done_slot;
    rbs_n   = (cnt_n != '0) && !land.bad;
    rel_len = pop ? head_slot.len : '0;
    dos_set = (pop && (cnt_n != '0) && land.bad)
            || (pop && (cnt_pop == '0) && ovf_pend)
            || (done && done_drop);
  end

  always_ff @(posedge clk) begin
    if (rst || reset_mode) begin
      wptr  <= '0;
      rptr  <= '0;
      fill  <= '0;
      cnt   <= '0;
      rbs_q <= 1'b0;
      rbs_d <= 1'b0;
      dos_q <= 1'b0;
      dos_d <= 1'b0;
      ri_q  <= 1'b0;
      doi_q <= 1'b0;
    end else begin
      wptr  <= wptr + AW'(store_en);
      rptr  <= rptr + AW'(rel_len);
      fill  <= fill + FW'(store_en) - FW'(rel_len);
      cnt   <= cnt_n;
      rbs_q <= rbs_n;
      rbs_d <= rbs_q;
      dos_q <= dos_set ? 1'b1 : (clr_ovr_cmd ? 1'b0 : dos_q);
      dos_d <= dos_q;
      ri_q  <= (rbs_q && !rbs_d) ? 1'b1 : (irq_rd ? 1'b0 : ri_q);
      doi_q <= (dos_q && !dos_d) ? 1'b1 : (irq_rd ? 1'b0 : doi_q);
    end
  end

  assign msg_count  = cnt;
  assign buf_status = rbs_q;
  assign ovr_status = dos_q;
  assign irq_flags  = {4'b0000, doi_q, 2'b00, ri_q};
endmodule

// File: rtl/can_rx_fifo_chk.sv
module can_rx_fifo_chk #(
  parameter  int SLOTS = 64,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          reset_mode,
  input logic          rx_valid,
  input logic          rel_cmd,
  input logic          clr_ovr_cmd,
  input logic [CW-1:0] msg_count,
  input logic          buf_status,
  input logic          ovr_status,
  input logic [7:0]    irq_flags
);
  // R9
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    msg_count <= CW'(SLOTS));

  // R2
  rbs_needs_msg_chk: assert property (@(posedge clk) disable iff (rst)
    buf_status |-> (msg_count != '0));

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_cmd && msg_count == '0 && !rx_valid && !reset_mode) |=> (msg_count == '0));

  // R3
  release_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_cmd && msg_count != '0 && !rx_valid && !reset_mode) |=>
      (msg_count == $past(msg_count) - CW'(1)));

  // R2
  rx_irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(buf_status) && !reset_mode) |=> irq_flags[0]);

  // R7
  ovr_irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovr_status) && !reset_mode) |=> irq_flags[3]);

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr_cmd && !rel_cmd && !rx_valid && !reset_mode) |=> !ovr_status);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    reset_mode |=> (msg_count == '0 && !buf_status && !ovr_status && irq_flags == 8'h00));

  // R8
  irq_spare_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flags[7:4] == 4'h0 && irq_flags[2:1] == 2'b00));
endmodule

bind can_rx_fifo can_rx_fifo_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .reset_mode(reset_mode), .rx_valid(rx_valid),
  .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd), .msg_count(msg_count),
  .buf_status(buf_status), .ovr_status(ovr_status), .irq_flags(irq_flags)
);

// File: tb/can_rx_fifo_test.sv
`timescale 1ns/1ps
module can_rx_fifo_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reset_mode = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         rel_cmd = 1'b0;
  logic         clr_ovr_cmd = 1'b0;
  logic         irq_rd = 1'b0;
  logic [103:0] win_bytes;
  logic [6:0]   msg_count;
  logic         buf_status, ovr_status;
  logic [7:0]   irq_flags;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  can_rx_fifo uut (
    .clk(clk), .rst(rst), .reset_mode(reset_mode), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd),
    .irq_rd(irq_rd), .win_bytes(win_bytes), .msg_count(msg_count),
    .buf_status(buf_status), .ovr_status(ovr_status), .irq_flags(irq_flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fsize(input int ext, input int dlc);
    return 1 + (ext != 0 ? 4 : 2) + (dlc > 8 ? 8 : dlc);
  endfunction

  function automatic int pat(input int f, input int k);
    return (f * 37 + k * 11 + 5) & 255;
  endfunction

  function automatic int info(input int ext, input int dlc);
    return (ext != 0 ? 128 : 0) + (dlc & 15);
  endfunction

  task automatic send_byte(input int b);
    rx_valid = 1'b1;
    rx_byte  = 8'(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input int f, input int ext, input int dlc);
    send_byte(info(ext, dlc));
    for (int k = 1; k < fsize(ext, dlc); k++) send_byte(pat(f, k));
  endtask

  task automatic check_window(input string tag, input int f, input int ext, input int dlc);
    for (int k = 0; k < fsize(ext, dlc); k++)
      chk(tag, int'(win_bytes[k*8 +: 8]), (k == 0) ? info(ext, dlc) : pat(f, k));
  endtask

  task automatic release_frame();
    rel_cmd = 1'b1;
    @(negedge clk);
    rel_cmd = 1'b0;
  endtask

  task automatic clear_ovr();
    clr_ovr_cmd = 1'b1;
    @(negedge clk);
    clr_ovr_cmd = 1'b0;
  endtask

  task automatic read_irq();
    irq_rd = 1'b1;
    @(negedge clk);
    irq_rd = 1'b0;
  endtask

  task automatic flush();
    reset_mode = 1'b1;
    @(negedge clk);
    reset_mode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset count", int'(msg_count), 0);
    chk("R10 reset rbs", int'(buf_status), 0);
    chk("R10 reset dos", int'(ovr_status), 0);
    chk("R10 reset irq", int'(irq_flags), 0);

    // R1 R2 R3 R8: sweep both formats and all length codes; window wraps many times
    for (int ext = 0; ext < 2; ext++) begin
      for (int dlc = 0; dlc < 16; dlc++) begin
        int f;
        f = ext * 16 + dlc;
        send_frame(f, ext, dlc);
        chk("R2 count after frame", int'(msg_count), 1);
        chk("R2 rbs after frame", int'(buf_status), 1);
        chk("R2 irq lag", int'(irq_flags[0]), 0);
        check_window("R1 window bytes", f, ext, dlc);
        @(negedge clk);
        chk("R2 irq set", int'(irq_flags), 1);
        read_irq();
        chk("R8 irq cleared", int'(irq_flags), 0);
        release_frame();
        chk("R3 count after release", int'(msg_count), 0);
        chk("R3 rbs after release", int'(buf_status), 0);
      end
    end

    // R8: a read in the cycle the flag is being set leaves it set
    send_frame(40, 0, 1);
    read_irq();
    chk("R8 set wins over read", int'(irq_flags[0]), 1);
    read_irq();
    chk("R8 cleared by read", int'(irq_flags[0]), 0);
    release_frame();
    // R3: release at zero is ignored
    release_frame();
    chk("R3 idle release count", int'(msg_count), 0);
    send_frame(41, 1, 3);
    check_window("R3 window after idle release", 41, 1, 3);
    release_frame();

    // R4 R5 R7: overflow then resynchronise
    flush();
    for (int i = 0; i < 4; i++) send_frame(50 + i, 1, 8);
    send_frame(54, 1, 8);
    chk("R4 overflowed frame counted", int'(msg_count), 5);
    chk("R4 no overrun yet", int'(ovr_status), 0);
    chk("R4 rbs on valid head", int'(buf_status), 1);
    send_frame(55, 0, 0);
    chk("R4 second overflowed frame counted", int'(msg_count), 6);
    check_window("R4 head frame intact", 50, 1, 8);
    release_frame();
    check_window("R3 next frame", 51, 1, 8);
    release_frame();
    release_frame();
    check_window("R3 fourth frame", 53, 1, 8);
    chk("R5 dos before landing", int'(ovr_status), 0);
    release_frame();
    chk("R5 dos on landing", int'(ovr_status), 1);
    chk("R5 rbs low on bad frame", int'(buf_status), 0);
    chk("R5 count", int'(msg_count), 2);
    chk("R7 irq lag", int'(irq_flags[3]), 0);
    @(negedge clk);
    chk("R7 overrun irq set", int'(irq_flags[3]), 1);
    clear_ovr();
    chk("R7 dos cleared", int'(ovr_status), 0);
    release_frame();
    chk("R5 dos on second bad frame", int'(ovr_status), 1);
    release_frame();
    chk("R3 count drained", int'(msg_count), 0);
    clear_ovr();
    read_irq();
    send_frame(56, 0, 2);
    chk("R2 count after resync", int'(msg_count), 1);
    chk("R2 rbs after resync", int'(buf_status), 1);
    check_window("R1 window after resync", 56, 0, 2);

    // R6: final release while the arriving frame has overflowed
    flush();
    for (int i = 0; i < 4; i++) send_frame(60 + i, 1, 8);
    send_frame(64, 1, 8);
    send_byte(info(0, 1));
    for (int i = 0; i < 4; i++) release_frame();
    chk("R5 dos landing", int'(ovr_status), 1);
    clear_ovr();
    chk("R7 dos cleared again", int'(ovr_status), 0);
    release_frame();
    chk("R6 count zero", int'(msg_count), 0);
    chk("R6 dos on last release", int'(ovr_status), 1);
    chk("R6 rbs low", int'(buf_status), 0);
    send_byte(pat(65, 1));
    send_byte(pat(65, 2));
    send_byte(pat(65, 3));
    chk("R4 partial frame counted", int'(msg_count), 1);
    chk("R4 rbs low on bad frame", int'(buf_status), 0);

    // R9: drive the counter to its limit
    flush();
    for (int i = 0; i < 64; i++) send_frame(70 + i, 0, 0);
    chk("R9 count at limit", int'(msg_count), 64);
    chk("R9 no dos yet", int'(ovr_status), 0);
    send_frame(200, 0, 0);
    chk("R9 count held", int'(msg_count), 64);
    chk("R9 dos at drop", int'(ovr_status), 1);
    check_window("R9 storage unchanged", 70, 0, 0);

    // R10: reset mode flushes and ignores bytes
    reset_mode = 1'b1;
    send_byte(info(1, 8));
    reset_mode = 1'b0;
    chk("R10 count flushed", int'(msg_count), 0);
    chk("R10 dos flushed", int'(ovr_status), 0);
    chk("R10 rbs flushed", int'(buf_status), 0);
    chk("R10 irq flushed", int'(irq_flags), 0);
    send_frame(210, 0, 0);
    chk("R10 byte ignored during reset mode", int'(msg_count), 1);
    check_window("R10 window after flush", 210, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule